// File: doc/BRIEF.md
# Multi-channel edge-programmed PWM generator

This block drives up to sixteen pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock into step ticks. A period counter advances once per tick and wraps after a programmed number of steps; that wrap is the period boundary. Each channel holds two step positions, one where its output goes high and one where it goes low. The ordering of the two positions sets the polarity, and their distance sets the pulse width. When the two positions are equal, the output instead toggles at every boundary.

Software programs the block through a plain synchronous write/read port. Channels that are named in a build-time mask keep newly written edge values in a holding copy. That copy moves into the active registers at a period boundary, but only while the update-enable register holds 1. All other channels take a written edge value on the next clock. A disabled channel holds its output low.

Top module: `edgepwm_top`

## Requirements
- R1: After a synchronous active-high reset, every output is 0 and every mapped address reads 0.
- R2: Address 0x00 holds the prescale value S and address 0x01 holds the period value P, both readable. One PWM period lasts (P+1)*(S+1) clock cycles.
- R3: When the falling position F is greater than the rising position R, the output is high for the steps R <= step < F, which is F-R steps per period. A value of F above P keeps the output high from step R to the end of the period.
- R4: When F < R, the polarity is inverted. The output is low for the steps F <= step < R, which is R-F steps, and high for the rest of the period.
- R5: When F equals R, the output toggles at each period boundary. This gives a 50% square wave whose period is twice the programmed one.
- R6: Bit i of address 0x02 enables channel i, and bit i of address 0x03 enables channel 8+i. A disabled channel outputs 0.
- R7: Channel n has its rising position at address 0x10+2n and its falling position at 0x11+2n. For a channel outside the shadow mask, a write is active and readable on the next cycle.
- R8: For a channel inside the shadow mask, a write goes to a holding copy and reads return the active value. The holding copy is transferred at a period boundary only while bit 0 of address 0x04 is 1.
- R9: Writes to unmapped addresses change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | AW (6) | Register address for both write and read |
| wr_data | input | DW (8) | Write data |
| rd_data | output | DW (8) | Combinational read of the register at addr |
| pwm_out | output | NCH (16) | Channel outputs, bit n is channel n |

## Verification
A register write lands at the clock edge that samples it, so the bench reads back at the following falling edge. Outputs are registered from the step counter and lag it by one cycle. Because of that lag, pulse width and polarity are measured as a count of high cycles over a window of exactly one period, or two periods for square-wave mode. Such a count does not depend on phase. Each measurement starts only after at least three full periods of settling, so a new configuration and any pending boundary transfer have taken effect. The period itself is measured as the spacing between consecutive rising edges.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;
   localparam int ADDR_PRESCALE = 'h00;
   localparam int ADDR_PERIOD   = 'h01;
   localparam int ADDR_EN_LO    = 'h02;
   localparam int ADDR_EN_HI    = 'h03;
   localparam int ADDR_SYNC     = 'h04;
   localparam int ADDR_EDGE0    = 'h10;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_INVERT = 2'd1,
      MODE_SQUARE = 2'd2
   } edge_mode_e;
endpackage

// File: rtl/edgepwm_timebase.sv
module edgepwm_timebase #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] prescale,
   input  logic [DW-1:0] period,
   output logic [DW-1:0] step,
   output logic          tick,
   output logic          boundary
);
   logic [DW-1:0] pre_cnt;

   assign tick     = (pre_cnt >= prescale);
   assign boundary = tick && (step >= period);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_cnt <= '0;
         step    <= '0;
      end else begin
         pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
         if (tick) step <= (step >= period) ? '0 : step + 1'b1;
      end
   end
endmodule

// File: rtl/edgepwm_chan.sv
module edgepwm_chan
   import edgepwm_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit SHADOWED = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_rise,
   input  logic          wr_fall,
   input  logic [DW-1:0] wdata,
   input  logic          boundary,
   input  logic          sync_en,
   input  logic [DW-1:0] step,
   input  logic          enable,
   output logic [DW-1:0] live_rise,
   output logic [DW-1:0] live_fall,
   output logic          pwm
);
   edge_mode_e mode;
   logic       tog;
   logic       level;

   generate
      if (SHADOWED) begin : g_shadow
         logic [DW-1:0] hold_rise, hold_fall;
         always_ff @(posedge clk) begin
            if (rst) begin
               hold_rise <= '0;
               hold_fall <= '0;
               live_rise <= '0;
               live_fall <= '0;
            end else begin
               if (wr_rise) hold_rise <= wdata;
               if (wr_fall) hold_fall <= wdata;
               if (boundary && sync_en) begin
                  live_rise <= hold_rise;
                  live_fall <= hold_fall;
               end
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (rst) begin
               live_rise <= '0;
               live_fall <= '0;
            end else begin
               if (wr_rise) live_rise <= wdata;
               if (wr_fall) live_fall <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      if (live_fall > live_rise)      mode = MODE_NORMAL;
      else if (live_fall < live_rise) mode = MODE_INVERT;
      else                            mode = MODE_SQUARE;
   end

   always_comb begin
      unique case (mode)
         MODE_NORMAL: level = (step >= live_rise) && (step < live_fall);
         MODE_INVERT: level = !((step >= live_fall) && (step < live_rise));
         default:     level = tog;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tog <= 1'b0;
         pwm <= 1'b0;
      end else begin
         if (mode != MODE_SQUARE) tog <= 1'b0;
         else if (boundary)       tog <= ~tog;
         pwm <= enable & level;
      end
   end
endmodule

// File: rtl/edgepwm_top.sv
module edgepwm_top
   import edgepwm_pkg::*;
#(
   parameter int              NCH         = 16,
   parameter int              DW          = 8,
   parameter int              AW          = 6,
   parameter logic [NCH-1:0]  SHADOW_MASK = 16'h00F0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic [NCH-1:0] pwm_out
);
   localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int EDGE_END = ADDR_EDGE0 + 2 * NCH;

   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("edgepwm_top: NCH must be 1..16");
      end
      if (DW < 8) begin : g_bad_dw
         $error("edgepwm_top: DW must be at least 8");
      end
      if (EDGE_END > (1 << AW)) begin : g_bad_aw
         $error("edgepwm_top: AW too small for the edge registers");
      end
   endgenerate

   logic [DW-1:0]          prescale_q, period_q;
   logic [7:0]             en_lo_q, en_hi_q;
   logic                   sync_q;
   logic [NCH-1:0]         en_all;
   logic [DW-1:0]          step;
   logic                   tick, boundary;
   logic [NCH-1:0]         wr_rise, wr_fall;
   logic [NCH-1:0][DW-1:0] live_rise, live_fall;

   assign en_all = NCH'({en_hi_q, en_lo_q});

   always_ff @(posedge clk) begin
      if (rst) begin
         prescale_q <= '0;
         period_q   <= '0;
         en_lo_q    <= '0;
         en_hi_q    <= '0;
         sync_q     <= 1'b0;
      end else if (wr_en) begin
         if (addr == AW'(ADDR_PRESCALE)) prescale_q <= wr_data;
         if (addr == AW'(ADDR_PERIOD))   period_q   <= wr_data;
         if (addr == AW'(ADDR_EN_LO))    en_lo_q    <= wr_data[7:0];
         if (addr == AW'(ADDR_EN_HI))    en_hi_q    <= wr_data[7:0];
         if (addr == AW'(ADDR_SYNC))     sync_q     <= wr_data[0];
      end
   end

   edgepwm_timebase #(.DW(DW)) u_tb (
      .clk      (clk),
      .rst      (rst),
      .prescale (prescale_q),
      .period   (period_q),
      .step     (step),
      .tick     (tick),
      .boundary (boundary)
   );

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         assign wr_rise[n] = wr_en && (addr == AW'(ADDR_EDGE0 + 2 * n));
         assign wr_fall[n] = wr_en && (addr == AW'(ADDR_EDGE0 + 2 * n + 1));
         edgepwm_chan #(.DW(DW), .SHADOWED(SHADOW_MASK[n])) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_rise   (wr_rise[n]),
            .wr_fall   (wr_fall[n]),
            .wdata     (wr_data),
            .boundary  (boundary),
            .sync_en   (sync_q),
            .step      (step),
            .enable    (en_all[n]),
            .live_rise (live_rise[n]),
            .live_fall (live_fall[n]),
            .pwm       (pwm_out[n])
         );
      end
   endgenerate

   logic [AW-1:0]  edge_off;
   logic [CHW-1:0] ch_sel;
   assign edge_off = addr - AW'(ADDR_EDGE0);
   assign ch_sel   = edge_off[CHW:1];

   always_comb begin
      rd_data = '0;
      if (addr == AW'(ADDR_PRESCALE))    rd_data = prescale_q;
      else if (addr == AW'(ADDR_PERIOD)) rd_data = period_q;
      else if (addr == AW'(ADDR_EN_LO))  rd_data = DW'(en_lo_q);
      else if (addr == AW'(ADDR_EN_HI))  rd_data = DW'(en_hi_q);
      else if (addr == AW'(ADDR_SYNC))   rd_data = DW'(sync_q);
      else if (addr >= AW'(ADDR_EDGE0) && int'(addr) < EDGE_END)
         rd_data = edge_off[0] ? live_fall[ch_sel] : live_rise[ch_sel];
   end
endmodule

// File: rtl/edgepwm_chk.sv
module edgepwm_chk #(
   parameter int             NCH         = 16,
   parameter int             DW          = 8,
   parameter int             AW          = 6,
   parameter logic [NCH-1:0] SHADOW_MASK = '0
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   tick,
   input logic                   boundary,
   input logic [DW-1:0]          step,
   input logic [NCH-1:0]         en_all,
   input logic [NCH-1:0]         pwm_out,
   input logic                   wr_en,
   input logic [AW-1:0]          addr,
   input logic [DW-1:0]          wr_data,
   input logic [NCH-1:0][DW-1:0] live_rise,
   input logic [NCH-1:0][DW-1:0] live_fall
);
   // R2: the step counter moves only on a prescaler tick
   a_r2_step_on_tick: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(step));

   // R2: a period boundary restarts the step count
   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
      boundary |=> (step == '0));

   // R6: a channel disabled in one cycle is low in the next
   a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((pwm_out & ~$past(en_all)) == '0));

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_c
         if (SHADOW_MASK[n]) begin : g_sh
            // R8: active values of a shadowed channel change only at a boundary
            a_r8_hold_until_boundary: assert property (@(posedge clk) disable iff (rst)
               !boundary |=> ($stable(live_rise[n]) && $stable(live_fall[n])));
         end else begin : g_dir
            // R7: an unshadowed rising-edge write is active on the next cycle
            a_r7_rise_immediate: assert property (@(posedge clk) disable iff (rst)
               (wr_en && addr == AW'(16 + 2 * n)) |=> (live_rise[n] == $past(wr_data)));
            a_r7_fall_immediate: assert property (@(posedge clk) disable iff (rst)
               (wr_en && addr == AW'(17 + 2 * n)) |=> (live_fall[n] == $past(wr_data)));
         end
      end
   endgenerate
endmodule

bind edgepwm_top edgepwm_chk #(
   .NCH(NCH), .DW(DW), .AW(AW), .SHADOW_MASK(SHADOW_MASK)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .boundary  (boundary),
   .step      (step),
   .en_all    (en_all),
   .pwm_out   (pwm_out),
   .wr_en     (wr_en),
   .addr      (addr),
   .wr_data   (wr_data),
   .live_rise (live_rise),
   .live_fall (live_fall)
);

// File: tb/edgepwm_top_tb.sv
`timescale 1ns/1ps
module edgepwm_top_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [15:0] pwm_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   edgepwm_top u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   // {prescale, period, rise, fall, window, expected high cycles}
   localparam logic [63:0] VEC [0:7] = '{
      {8'd0, 8'd9,  8'd2, 8'd5,  16'd10, 16'd3},
      {8'd1, 8'd9,  8'd2, 8'd7,  16'd20, 16'd10},
      {8'd2, 8'd7,  8'd6, 8'd2,  16'd24, 16'd12},
      {8'd0, 8'd15, 8'd0, 8'd15, 16'd16, 16'd15},
      {8'd0, 8'd9,  8'd8, 8'd1,  16'd10, 16'd3},
      {8'd3, 8'd4,  8'd0, 8'd5,  16'd20, 16'd20},
      {8'd0, 8'd4,  8'd3, 8'd3,  16'd10, 16'd5},
      {8'd1, 8'd3,  8'd2, 8'd2,  16'd16, 16'd8}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic count_high(input int ch, input int n, output int c);
      c = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch]) c++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int c, t0, t1;
      int nz;
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      nz = 0;
      for (int a = 0; a < 48; a++) begin
         rd(6'(a), d);
         if (d != 0) nz++;
      end
      check(nz == 0, "R1 nonzero reads", nz, 0);
      check(pwm_out == 16'h0, "R1 outputs", int'(pwm_out), 0);

      // R2: readback of the shared time base registers
      wr(6'h00, 8'd3); wr(6'h01, 8'd11);
      rd(6'h00, d); check(d == 8'd3, "R2 prescale readback", d, 3);
      rd(6'h01, d); check(d == 8'd11, "R2 period readback", d, 11);

      // R3 R4 R5: vector table on channel 0 (unshadowed)
      wr(6'h02, 8'h01);
      for (int v = 0; v < 8; v++) begin
         wr(6'h00, VEC[v][63:56]);
         wr(6'h01, VEC[v][55:48]);
         wr(6'h10, VEC[v][47:40]);
         wr(6'h11, VEC[v][39:32]);
         idle(3 * int'(VEC[v][31:16]) + 4);
         count_high(0, int'(VEC[v][31:16]), c);
         check(c == int'(VEC[v][15:0]), $sformatf("R3 R4 R5 vector %0d", v), c, int'(VEC[v][15:0]));
      end

      // R2: period length (P+1)*(S+1) = 5*3 = 15 cycles between rising edges
      wr(6'h00, 8'd2); wr(6'h01, 8'd4);
      wr(6'h10, 8'd0); wr(6'h11, 8'd1);
      idle(50);
      @(negedge clk); while (pwm_out[0]) @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
      t0 = $time;
      while (pwm_out[0]) @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
      t1 = $time;
      check((t1 - t0) == 75, "R2 period cycles", (t1 - t0) / 5, 15);

      // R7: immediate readback on unshadowed channels
      wr(6'h10, 8'h5A); rd(6'h10, d); check(d == 8'h5A, "R7 ch0 rise", d, 'h5A);
      wr(6'h13, 8'hC3); rd(6'h13, d); check(d == 8'hC3, "R7 ch1 fall", d, 'hC3);

      // R8: shadowed channel 4 (rise 0x18, fall 0x19)
      wr(6'h00, 8'd0); wr(6'h01, 8'd9);
      wr(6'h02, 8'h10);
      wr(6'h18, 8'd2); wr(6'h19, 8'd5);
      idle(40);
      rd(6'h18, d); check(d == 8'd0, "R8 held rise read", d, 0);
      count_high(4, 20, c); check(c == 10, "R8 held output square", c, 10);
      wr(6'h04, 8'h01);
      idle(30);
      rd(6'h18, d); check(d == 8'd2, "R8 transferred rise", d, 2);
      rd(6'h19, d); check(d == 8'd5, "R8 transferred fall", d, 5);
      count_high(4, 20, c); check(c == 6, "R8 transferred output", c, 6);
      wr(6'h04, 8'h00);
      wr(6'h18, 8'd7);
      idle(40);
      rd(6'h18, d); check(d == 8'd2, "R8 no transfer when sync off", d, 2);

      // R6: upper enable register, channel 9 (reset edges equal -> square)
      wr(6'h02, 8'h00); wr(6'h03, 8'h02);
      idle(40);
      count_high(9, 20, c); check(c == 10, "R6 ch9 enabled", c, 10);
      count_high(1, 20, c); check(c == 0, "R6 ch1 disabled", c, 0);
      count_high(0, 20, c); check(c == 0, "R6 ch0 disabled", c, 0);

      // R9: unmapped address
      wr(6'h3F, 8'hFF); wr(6'h05, 8'hFF);
      rd(6'h3F, d); check(d == 8'd0, "R9 unmapped 0x3F", d, 0);
      rd(6'h05, d); check(d == 8'd0, "R9 unmapped 0x05", d, 0);
      rd(6'h01, d); check(d == 8'd9, "R9 period untouched", d, 9);
      rd(6'h03, d); check(d == 8'h02, "R9 enable untouched", d, 2);

      // R1: reset again mid-run
      @(negedge clk); rst = 1'b1;
      idle(2);
      rst = 1'b0;
      rd(6'h18, d); check(d == 8'd0, "R1 rise cleared", d, 0);
      check(pwm_out == 16'h0, "R1 outputs after reset", int'(pwm_out), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule